// File: doc/BRIEF.md
# Two-Speed Linear Systolic Matrix Multiplier

This block computes the product C = A·B of two square m×m signed matrices on a single chain of m² processing cells. Operands enter one pair per clock through the leftmost cell: matrix A column by column, matrix B row by row. Each cell owns one multiply-accumulate unit and one partial-sum register and builds exactly one element of C. The cells are grouped into m blocks of m cells, and block i produces row i of C.

Operands are aligned by running registered channels at two speeds. A and a travelling enable tag move on a slow channel of two registers per cell. B moves on a slow channel of the same speed and on a fast channel of one register per cell. Inside a block, B travels on the fast channel and overtakes the slow A operand, so the single enabled A value meets one B value per cell. At each block boundary the fast channel is dropped and reloaded from the slow B channel through a one-register hand-off stage. In the same stage the enable tag moves onto the next A value in the stream. When the last product has been added, the block raises a one-cycle done flag. The partial-sum registers then form a shift chain that presents the m² results in row-major order.

Top module: `systolic_matmul`

## Requirements
- R1: While reset is low, and after its release until a start is accepted, `busy`, `done` and `resValid` are low.
- R2: When `start` is high at a clock edge s while the block is idle, operand A(i,k) is sampled from `aIn` at edge s+1+k·m+i (column-major), and B(k,j) is sampled from `bIn` at edge s+1+k·m+j (row-major). Indices i, j and k start at 0.
- R3: Every result equals the exact signed sum Σk A(i,k)·B(k,j). `resData` is 2·DW+log2(m) bits wide, so operands of −2^(DW−1) or 2^(DW−1)−1 in every position give no overflow.
- R4: For each accepted start, `done` is high for exactly one cycle. That cycle follows clock edge s+3m²−1.
- R5: `resValid` is high for exactly m² consecutive cycles, starting in the cycle right after `done`. `resData` carries C(0,0), C(0,1), …, C(m−1,m−1) in row-major order.
- R6: A `start` pulse while `busy` is high is ignored. The run in progress keeps its timing and its results.
- R7: Values on `aIn` and `bIn` at edges outside the m² sampling edges of R2 have no effect on any result.
- R8: Every accepted start clears all partial sums. A run started in the first idle cycle after the previous unload returns only its own product.
- R9: `busy` is high from the cycle after edge s through the last `resValid` cycle. It is low in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Accepted when idle: clears the sums and opens the operand window |
| aIn | input | DW | Signed element of A, column-major stream |
| bIn | input | DW | Signed element of B, row-major stream |
| busy | output | 1 | A multiply or its unload is in progress |
| done | output | 1 | One-cycle flag: all products have been accumulated |
| resValid | output | 1 | `resData` holds a result this cycle |
| resData | output | 2·DW+log2(DIM) | Signed result element, row-major |

## Verification
The block has no input handshake. The checks assume that the operand pairs arrive on exactly the m² edges after an accepted start, with no gap and no stall. They also assume that `start` only matters in the idle state. The bench keeps to this with a driver task that places one element per clock on falling edges, starting the cycle after the start pulse. Outside that window the driver puts deliberately wrong values on the operand pins. In noisy runs it also pulses `start` again while the block is busy, to show that neither has any effect.

// File: rtl/systolic_matmul_pkg.sv
package systolic_matmul_pkg;

  // Strobes the sequencer hands to the datapath each cycle.
  typedef struct packed {
    logic feedEn;    // operand pins are routed into the chain this cycle
    logic tagFirst;  // the value entering now belongs to the first row of A
    logic clearAcc;  // zero every partial sum
    logic shiftOut;  // move partial sums one cell toward the output
  } ctrlStrb_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_DRAIN,
    ST_FINISH,
    ST_UNLOAD
  } ctrlState_t;

endpackage

// File: rtl/smm_ctrl.sv
module smm_ctrl
  import systolic_matmul_pkg::*;
#(
  parameter int DIM = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output ctrlStrb_t strb,
  output logic      busy,
  output logic      done,
  output logic      resValid
);

  localparam int CELLS = DIM * DIM;
  localparam int CNT_W = $clog2(2 * CELLS);
  localparam int PH_W  = (DIM > 1) ? $clog2(DIM) : 1;

  ctrlState_t state;
  logic [CNT_W-1:0] cnt;
  logic [PH_W-1:0]  phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      phase <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_LOAD;
            cnt   <= '0;
            phase <= '0;
          end
        end
        ST_LOAD: begin
          cnt   <= cnt + 1'b1;
          phase <= (phase == PH_W'(DIM - 1)) ? '0 : phase + 1'b1;
          if (cnt == CNT_W'(CELLS - 1)) begin
            state <= ST_DRAIN;
            cnt   <= '0;
          end
        end
        ST_DRAIN: begin
          cnt <= cnt + 1'b1;
          // the last tagged A value reaches the final cell 2*CELLS-1 edges after loading ends
          if (cnt == CNT_W'(2 * CELLS - 2)) begin
            state <= ST_FINISH;
          end
        end
        ST_FINISH: begin
          state <= ST_UNLOAD;
          cnt   <= '0;
        end
        ST_UNLOAD: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(CELLS - 1)) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.feedEn   = (state == ST_LOAD);
    strb.tagFirst = (state == ST_LOAD) && (phase == '0);
    strb.clearAcc = (state == ST_IDLE) && start;
    strb.shiftOut = (state == ST_UNLOAD);
  end

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_FINISH);
  assign resValid = (state == ST_UNLOAD);

endmodule

// File: rtl/smm_handoff.sv
// Boundary stage between two blocks: delays slow B and the enable tag by one
// clock, which lines row i+1 of A up with the B rows of the next block.
module smm_handoff #(
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic signed [DW-1:0] bsFromPrev,
  input  logic                 tagFromPrev,
  output logic signed [DW-1:0] bsHeld,
  output logic                 tagHeld
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bsHeld  <= '0;
      tagHeld <= 1'b0;
    end else begin
      bsHeld  <= bsFromPrev;
      tagHeld <= tagFromPrev;
    end
  end

endmodule

// File: rtl/smm_pe.sv
// One cell: two-register slow channels for A (with its tag) and B, a
// one-register fast B channel, and a partial sum that doubles as a shift stage.
module smm_pe #(
  parameter int DW   = 8,
  parameter int ACCW = 18
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   clearAcc,
  input  logic                   shiftOut,
  input  logic signed [DW-1:0]   aEnt,
  input  logic                   tagEnt,
  input  logic signed [DW-1:0]   bsEnt,
  input  logic signed [DW-1:0]   bfSrc,
  input  logic signed [ACCW-1:0] accRight,
  output logic signed [DW-1:0]   aOut,
  output logic                   tagOut,
  output logic signed [DW-1:0]   bsOut,
  output logic signed [DW-1:0]   bfCur,
  output logic signed [ACCW-1:0] accCur
);

  logic signed [DW-1:0]   aSlowIn, aSlowOut;
  logic                   tagIn, tagLate;
  logic signed [DW-1:0]   bsSlowIn, bsSlowOut;
  logic signed [DW-1:0]   bFast;
  logic signed [ACCW-1:0] acc;
  logic signed [2*DW-1:0] prod;

  always_comb prod = aSlowIn * bFast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aSlowIn   <= '0;
      aSlowOut  <= '0;
      tagIn     <= 1'b0;
      tagLate   <= 1'b0;
      bsSlowIn  <= '0;
      bsSlowOut <= '0;
      bFast     <= '0;
      acc       <= '0;
    end else begin
      aSlowIn   <= aEnt;
      aSlowOut  <= aSlowIn;
      tagIn     <= tagEnt;
      tagLate   <= tagIn;
      bsSlowIn  <= bsEnt;
      bsSlowOut <= bsSlowIn;
      bFast     <= bfSrc;
      if (clearAcc) begin
        acc <= '0;
      end else if (shiftOut) begin
        acc <= accRight;
      end else if (tagIn) begin
        acc <= acc + ACCW'(prod);
      end
    end
  end

  assign aOut   = aSlowOut;
  assign tagOut = tagLate;
  assign bsOut  = bsSlowOut;
  assign bfCur  = bFast;
  assign accCur = acc;

endmodule

// File: rtl/smm_datapath.sv
module smm_datapath
  import systolic_matmul_pkg::*;
#(
  parameter int DIM  = 4,
  parameter int DW   = 8,
  parameter int ACCW = 18
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrb_t              strb,
  input  logic signed [DW-1:0]   aIn,
  input  logic signed [DW-1:0]   bIn,
  output logic signed [ACCW-1:0] resData
);

  localparam int CELLS = DIM * DIM;

  logic signed [DW-1:0]   aFeed, bFeed;
  logic                   tagFeed;

  logic signed [DW-1:0]   aOutArr  [CELLS];
  logic                   tagOutArr[CELLS];
  logic signed [DW-1:0]   bsOutArr [CELLS];
  logic signed [DW-1:0]   bfArr    [CELLS];
  logic signed [ACCW-1:0] accArr   [CELLS];

  // Outside the operand window the chain is fed zeros with no tag.
  assign aFeed   = strb.feedEn ? aIn : '0;
  assign bFeed   = strb.feedEn ? bIn : '0;
  assign tagFeed = strb.tagFirst;

  for (genvar q = 0; q < CELLS; q++) begin : g_cell
    localparam int COL = q % DIM;

    logic signed [DW-1:0]   aEnt, bsEnt, bfSrc;
    logic                   tagEnt;
    logic signed [ACCW-1:0] accRight;

    if (q == 0) begin : g_entry
      assign aEnt   = aFeed;
      assign tagEnt = tagFeed;
      assign bsEnt  = bFeed;
      assign bfSrc  = bFeed;
    end else if (COL == 0) begin : g_blockHead
      logic signed [DW-1:0] bsHeld;
      logic                 tagHeld;

      smm_handoff #(.DW(DW)) u_handoff (
        .clk        (clk),
        .rstN       (rstN),
        .bsFromPrev (bsOutArr[q-1]),
        .tagFromPrev(tagOutArr[q-1]),
        .bsHeld     (bsHeld),
        .tagHeld    (tagHeld)
      );

      // fast channel of the previous block is dropped here
      assign aEnt   = aOutArr[q-1];
      assign tagEnt = tagHeld;
      assign bsEnt  = bsHeld;
      assign bfSrc  = bsHeld;
    end else begin : g_inner
      assign aEnt   = aOutArr[q-1];
      assign tagEnt = tagOutArr[q-1];
      assign bsEnt  = bsOutArr[q-1];
      assign bfSrc  = bfArr[q-1];
    end

    if (q == CELLS - 1) begin : g_tail
      assign accRight = '0;
    end else begin : g_link
      assign accRight = accArr[q+1];
    end

    smm_pe #(.DW(DW), .ACCW(ACCW)) u_pe (
      .clk     (clk),
      .rstN    (rstN),
      .clearAcc(strb.clearAcc),
      .shiftOut(strb.shiftOut),
      .aEnt    (aEnt),
      .tagEnt  (tagEnt),
      .bsEnt   (bsEnt),
      .bfSrc   (bfSrc),
      .accRight(accRight),
      .aOut    (aOutArr[q]),
      .tagOut  (tagOutArr[q]),
      .bsOut   (bsOutArr[q]),
      .bfCur   (bfArr[q]),
      .accCur  (accArr[q])
    );
  end

  assign resData = accArr[0];

endmodule

// File: rtl/systolic_matmul.sv
module systolic_matmul
  import systolic_matmul_pkg::*;
#(
  parameter int DIM = 4,
  parameter int DW  = 8,
  localparam int ACCW = 2 * DW + $clog2(DIM)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic signed [DW-1:0]   aIn,
  input  logic signed [DW-1:0]   bIn,
  output logic                   busy,
  output logic                   done,
  output logic                   resValid,
  output logic signed [ACCW-1:0] resData
);

  ctrlStrb_t strb;

  smm_ctrl #(.DIM(DIM)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strb    (strb),
    .busy    (busy),
    .done    (done),
    .resValid(resValid)
  );

  smm_datapath #(.DIM(DIM), .DW(DW), .ACCW(ACCW)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .aIn    (aIn),
    .bIn    (bIn),
    .resData(resData)
  );

endmodule

// File: rtl/systolic_matmul_chk.sv
module systolic_matmul_chk #(
  parameter int DIM = 4
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done,
  input logic resValid
);

  localparam int CELLS = DIM * DIM;

  int elapsed;
  int validRun;

  // edges since the accepted start, counted in the checker (window too long for $past)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      elapsed <= 0;
    end else if (start && !busy) begin
      elapsed <= 1;
    end else if (elapsed != 0 && elapsed < 32'h4000_0000) begin
      elapsed <= elapsed + 1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validRun <= 0;
    end else if (resValid) begin
      validRun <= validRun + 1;
    end else begin
      validRun <= 0;
    end
  end

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r4_done_latency: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (elapsed == 3 * CELLS));

  a_r5_valid_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |=> resValid);

  a_r5_valid_run: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resValid) |-> (validRun == CELLS));

  a_r9_valid_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> busy);

  a_r6_busy_needs_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

endmodule

bind systolic_matmul systolic_matmul_chk #(.DIM(DIM)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .resValid(resValid)
);

// File: tb/systolic_matmul_tb.sv
`timescale 1ns/1ps
module systolic_matmul_tb;

  localparam int DIM   = 4;
  localparam int DW    = 8;
  localparam int CELLS = DIM * DIM;
  localparam int ACCW  = 2 * DW + $clog2(DIM);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic signed [DW-1:0] aIn = '0;
  logic signed [DW-1:0] bIn = '0;
  logic busy, done, resValid;
  logic signed [ACCW-1:0] resData;

  always #4 clk = ~clk;  // 125 MHz

  systolic_matmul #(.DIM(DIM), .DW(DW)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .aIn(aIn), .bIn(bIn),
    .busy(busy), .done(done), .resValid(resValid), .resData(resData)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int sCyc = 0;
  int runs = 0;
  int doneCount = 0;
  int resIdx = 0;
  int expV;
  string tagV;
  bit prevDone = 0;
  bit prevValid = 0;
  int seed = 32'h1357_9bdf;
  int expQ[$];
  string tagQ[$];
  int matA[DIM][DIM];
  int matB[DIM][DIM];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nextVal();
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 16) & 255) - 128;
  endfunction

  // Scoreboard driver: pushes the expected row-major results, then feeds operands.
  // R2: A(i,k) goes in at step k*DIM+i, B(k,j) at step k*DIM+j.
  task automatic runMatrix(input string label, input bit noisy);
    while (busy) @(negedge clk);
    for (int i = 0; i < DIM; i++) begin
      for (int j = 0; j < DIM; j++) begin
        int sum = 0;
        for (int k = 0; k < DIM; k++) sum += matA[i][k] * matB[k][j];
        expQ.push_back(sum);
        tagQ.push_back(label);
      end
    end
    runs++;
    start = 1'b1;
    if (noisy) begin  // R7: junk on the operand pins during the start cycle
      aIn = 8'sd99;
      bIn = -8'sd77;
    end
    @(negedge clk);
    start = 1'b0;
    sCyc = cyc;
    check(busy == 1'b1, "R9 busy after start", busy, 1);
    for (int t = 0; t < CELLS; t++) begin
      aIn = DW'(matA[t % DIM][t / DIM]);
      bIn = DW'(matB[t / DIM][t % DIM]);
      @(negedge clk);
    end
    if (noisy) begin  // R6 start while busy, R7 junk after the window
      aIn = 8'sd127;
      bIn = -8'sd128;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      aIn = -8'sd5;
      repeat (5) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    aIn = '0;
    bIn = '0;
  endtask

  // Monitor: pops and compares as results appear.
  always @(negedge clk) begin
    if (rstN) begin
      if (done) begin
        doneCount++;
        check(cyc - sCyc == 3 * CELLS - 1, "R4 done latency", cyc - sCyc, 3 * CELLS - 1);
      end
      if (prevDone) check(resValid == 1'b1, "R5 results follow done", resValid, 1);
      if (resValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R5 unexpected result", int'(resData), 0);
        end else begin
          expV = expQ.pop_front();
          tagV = tagQ.pop_front();
          check(int'(resData) == expV,
                $sformatf("%s C[%0d][%0d]", tagV, resIdx / DIM, resIdx % DIM),
                int'(resData), expV);
        end
        resIdx = (resIdx + 1) % CELLS;
      end
      if (prevValid && !resValid) check(busy == 1'b0, "R9 idle after last result", busy, 0);
      prevDone  = done;
      prevValid = resValid;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    check(busy == 1'b0, "R1 busy in reset", busy, 0);
    check(done == 1'b0, "R1 done in reset", done, 0);
    check(resValid == 1'b0, "R1 resValid in reset", resValid, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && resValid == 1'b0, "R1 idle after reset",
          {busy, done, resValid}, 0);

    // identity times a patterned B gives B (R2 ordering)
    for (int i = 0; i < DIM; i++)
      for (int j = 0; j < DIM; j++) begin
        matA[i][j] = (i == j) ? 1 : 0;
        matB[i][j] = nextVal();
      end
    runMatrix("R2 identity product", 1'b0);

    // general operands with noise, extra starts and junk (R6, R7)
    for (int i = 0; i < DIM; i++)
      for (int j = 0; j < DIM; j++) begin
        matA[i][j] = nextVal();
        matB[i][j] = nextVal();
      end
    runMatrix("R6 R7 noisy general product", 1'b1);

    // R3 extremes: most negative times most negative
    for (int i = 0; i < DIM; i++)
      for (int j = 0; j < DIM; j++) begin
        matA[i][j] = -128;
        matB[i][j] = -128;
      end
    runMatrix("R3 extreme positive sums", 1'b0);

    // R3 extremes of opposite sign, started back-to-back (R8)
    for (int i = 0; i < DIM; i++)
      for (int j = 0; j < DIM; j++) matB[i][j] = 127;
    runMatrix("R8 R3 back-to-back negative sums", 1'b0);

    // R8 another back-to-back run with unrelated operands
    for (int i = 0; i < DIM; i++)
      for (int j = 0; j < DIM; j++) begin
        matA[i][j] = nextVal();
        matB[i][j] = (i + 1) * (j - 2);
      end
    runMatrix("R8 fresh sums", 1'b0);

    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R5 all results delivered", expQ.size(), 0);
    check(doneCount == runs, "R4 one done per run", doneCount, runs);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule